// File: doc/BRIEF.md
# Plasma Subfield Drive Sequencer

This block produces the logic-level strobes that drive a three-electrode AC plasma panel when each picture field is broken into eight binary-weighted subfields. A field begins with a one-cycle pulse on `field_start`. The block then works through subfields 0 to 7 in order. Each subfield has an address period and then a display period. The address period is a reset step followed by a row-by-row address step. The display period is a burst of sustain pulses whose length sets the luminance weight of that subfield.

The reset step raises `bulk_write` for a programmed number of cycles and then `bulk_erase` for another programmed number. The address step starts with one prefetch slot, one address cycle long. After that, rows `0 .. cfg_rows-1` are scanned one at a time, and each row's scan strobe lasts exactly one address cycle. Column enables are taken from an external bit-plane store. Subfield k uses bit k of every pixel's 8-bit grey value. The read for a row is issued one address cycle before that row is scanned. The sustain address bias stays high across the whole address step. The display period of subfield k produces `cfg_sus_base << k` sustain pulses. They alternate between the two display electrodes, X first, and each pulse is `cfg_sus_width` cycles wide.

The controller is a six-state machine:
- Idle goes to Bulk-write on `field_start`.
- Bulk-write goes to Bulk-erase, and Bulk-erase goes to Prefetch, each when its dwell expires.
- Prefetch goes to Scan after one address cycle.
- Scan goes back to Scan for the next row while rows remain.
- After the last row, Scan goes to Sustain, or skips straight to the end of the subfield when the pulse count is zero.
- Sustain ends the subfield after its last pulse.
- The end of a subfield goes to Bulk-write for the next subfield, or to Idle after subfield 7.

Top module: `pdp_subfield_seq`

## Requirements
- R1: After reset every strobe output is low: `bulk_write`, `bulk_erase`, `scan_en`, `col_en`, `sus_bias`, `sus_x`, `sus_y`, `plane_req` and `overrun`. The block is idle.
- R2: The first cycle after a sampled `field_start` begins subfield 0. Each subfield then holds `bulk_write` alone for `cfg_write_len` cycles, followed by `bulk_erase` alone for `cfg_erase_len` cycles. Subfields run strictly in the order 0 to 7.
- R3: After the erase, `sus_bias` rises alone, with no scan, for one address cycle (the prefetch slot). It then stays high through every row scan and drops when the address step ends.
- R4: Rows 0 to `cfg_rows-1` are scanned in ascending order. For each row, `scan_en` is high and `scan_row` equals the row index for exactly `cfg_addr_cyc` cycles. `scan_row` reads 0 whenever `scan_en` is low.
- R5: While row r is scanned in subfield k, `col_en[c]` equals bit k of that pixel's grey value. Outside a scan, `col_en` is zero. The read interface works as follows: `plane_req` is high for one cycle with `plane_sf` = k and `plane_row` = r, and `plane_data` is sampled on the following cycle. Bit c of `plane_data` is column c.
- R6: The display period of subfield k has `cfg_sus_base << k` pulses. Each pulse is `cfg_sus_width` cycles wide. The first pulse is on `sus_x`, and the pulses alternate with `sus_y` with no gap. The two are never high together.
- R7: When `cfg_sus_base` is 0, no display period is produced. The next subfield's bulk write follows the last row scan directly.
- R8: A `field_start` that arrives while a field is running raises `overrun` for exactly one cycle, in the following cycle. That pulse leaves the running field unchanged.
- R9: After the last sustain pulse of subfield 7, all strobes go low and stay low until the next `field_start`.
- R10: Configured values of 0 for the write length, erase length or sustain width act as 1. An address cycle below 2 acts as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_start | input | 1 | One-cycle pulse that starts a field |
| cfg_rows | input | ROW_W | Number of scan rows (0 acts as 1) |
| cfg_write_len | input | CNT_W | Bulk-write dwell in cycles |
| cfg_erase_len | input | CNT_W | Bulk-erase dwell in cycles |
| cfg_addr_cyc | input | CNT_W | Address cycle period in cycles |
| cfg_sus_width | input | CNT_W | Width of each sustain pulse in cycles |
| cfg_sus_base | input | CNT_W | Sustain pulse count of subfield 0 |
| plane_data | input | NCOL | Bit-plane row data, one cycle after the request |
| plane_req | output | 1 | Bit-plane read request |
| plane_sf | output | SF_W | Subfield (bit plane) being requested |
| plane_row | output | ROW_W | Row being requested |
| bulk_write | output | 1 | Reset-step bulk write strobe |
| bulk_erase | output | 1 | Reset-step bulk erase strobe |
| scan_en | output | 1 | Scan pulse active |
| scan_row | output | ROW_W | Row receiving the scan pulse |
| col_en | output | NCOL | Column data pulse enables |
| sus_bias | output | 1 | Sustain address bias during addressing |
| sus_x | output | 1 | Sustain pulse on X display electrodes |
| sus_y | output | 1 | Sustain pulse on Y display electrodes |
| overrun | output | 1 | Field start arrived during a running field |

## Verification
The bench replays whole fields cycle by cycle against a model of the phase sequence. This shows up an off-by-one dwell, such as a write, erase, address cycle or pulse width one cycle long or short, because every later phase then lands at the wrong cycle. Column data is compared per row and per subfield against a grey-value pattern with different bits in every plane. A design that used the wrong bit plane, or latched row r+1's data while row r was still scanning, would show wrong enables. Further scenarios cover a single-row panel, a zero sustain base (a design that emitted a stray pulse or an extra dwell would misalign the next bulk write), zero and one configuration values that must clamp, and a field start injected mid-field that must raise one overrun cycle without restarting or lengthening the field.

// File: rtl/pdp_seq_pkg.sv
package pdp_seq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_BWRITE,
        SQ_BERASE,
        SQ_PREFETCH,
        SQ_SCAN,
        SQ_SUSTAIN
    } seq_state_e;
endpackage

// File: rtl/pdp_dwell_timer.sv
module pdp_dwell_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    // load_val is a dwell of at least one cycle; the counter holds cycles left minus one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val - CNT_W'(1);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/pdp_sustain_pair.sv
module pdp_sustain_pair #(
    parameter int CNT_W = 12,
    parameter int TOT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TOT_W-1:0] total,
    input  logic [CNT_W-1:0] width,
    output logic             drive_x,
    output logic             drive_y,
    output logic             done
);
    logic             active_q;
    logic             phase_q;
    logic [CNT_W-1:0] wcnt_q;
    logic [TOT_W-1:0] pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            wcnt_q   <= '0;
            pcnt_q   <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            phase_q  <= 1'b0;
            wcnt_q   <= width - CNT_W'(1);
            pcnt_q   <= total - TOT_W'(1);
        end else if (active_q) begin
            if (wcnt_q != '0) begin
                wcnt_q <= wcnt_q - CNT_W'(1);
            end else if (pcnt_q == '0) begin
                active_q <= 1'b0;
            end else begin
                pcnt_q  <= pcnt_q - TOT_W'(1);
                phase_q <= ~phase_q;
                wcnt_q  <= width - CNT_W'(1);
            end
        end
    end

    assign drive_x = active_q & ~phase_q;
    assign drive_y = active_q & phase_q;
    assign done    = active_q && (wcnt_q == '0) && (pcnt_q == '0);

    AST_SUS_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && $past(wcnt_q) == '0 && !$past(start))
            |-> (phase_q != $past(phase_q))); // R6
    AST_SUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && $past(active_q) && $past(wcnt_q) != '0 && !$past(start))
            |-> (phase_q == $past(phase_q))); // R6
endmodule

// File: rtl/pdp_subfield_seq.sv
module pdp_subfield_seq
    import pdp_seq_pkg::*;
#(
    parameter int NUM_SF = 8,
    parameter int ROW_W  = 8,
    parameter int NCOL   = 8,
    parameter int CNT_W  = 12,
    localparam int SF_W  = $clog2(NUM_SF),
    localparam int TOT_W = CNT_W + NUM_SF - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic [ROW_W-1:0] cfg_rows,
    input  logic [CNT_W-1:0] cfg_write_len,
    input  logic [CNT_W-1:0] cfg_erase_len,
    input  logic [CNT_W-1:0] cfg_addr_cyc,
    input  logic [CNT_W-1:0] cfg_sus_width,
    input  logic [CNT_W-1:0] cfg_sus_base,
    input  logic [NCOL-1:0]  plane_data,
    output logic             plane_req,
    output logic [SF_W-1:0]  plane_sf,
    output logic [ROW_W-1:0] plane_row,
    output logic             bulk_write,
    output logic             bulk_erase,
    output logic             scan_en,
    output logic [ROW_W-1:0] scan_row,
    output logic [NCOL-1:0]  col_en,
    output logic             sus_bias,
    output logic             sus_x,
    output logic             sus_y,
    output logic             overrun
);
    seq_state_e       state_q, state_d;
    logic [SF_W-1:0]  sf_q;
    logic [ROW_W-1:0] row_q;
    logic [NCOL-1:0]  pend_q, cur_q;
    logic             first_q, req_d1_q, overrun_q;

    logic             tmr_load, tmr_last, sus_start, sus_done, sf_end;
    logic [CNT_W-1:0] tmr_val;

    // clamped configuration (R10)
    logic [CNT_W-1:0] w_eff, e_eff, ac_eff, sw_eff;
    logic [ROW_W-1:0] rows_last;
    logic [TOT_W-1:0] sus_total;
    logic             last_sf;

    assign w_eff     = (cfg_write_len == '0) ? CNT_W'(1) : cfg_write_len;
    assign e_eff     = (cfg_erase_len == '0) ? CNT_W'(1) : cfg_erase_len;
    assign sw_eff    = (cfg_sus_width == '0) ? CNT_W'(1) : cfg_sus_width;
    assign ac_eff    = (cfg_addr_cyc < CNT_W'(2)) ? CNT_W'(2) : cfg_addr_cyc;
    assign rows_last = (cfg_rows == '0) ? '0 : cfg_rows - ROW_W'(1);
    assign sus_total = TOT_W'(cfg_sus_base) << sf_q;
    assign last_sf   = (sf_q == SF_W'(NUM_SF - 1));

    pdp_dwell_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
    );

    pdp_sustain_pair #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_sustain (
        .clk(clk), .rst_n(rst_n), .start(sus_start), .total(sus_total),
        .width(sw_eff), .drive_x(sus_x), .drive_y(sus_y), .done(sus_done)
    );

    // next state
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sus_start = 1'b0;
        sf_end    = 1'b0;
        unique case (state_q)
            SQ_IDLE: if (field_start) begin
                state_d = SQ_BWRITE; tmr_load = 1'b1; tmr_val = w_eff;
            end
            SQ_BWRITE: if (tmr_last) begin
                state_d = SQ_BERASE; tmr_load = 1'b1; tmr_val = e_eff;
            end
            SQ_BERASE: if (tmr_last) begin
                state_d = SQ_PREFETCH; tmr_load = 1'b1; tmr_val = ac_eff;
            end
            SQ_PREFETCH: if (tmr_last) begin
                state_d = SQ_SCAN; tmr_load = 1'b1; tmr_val = ac_eff;
            end
            SQ_SCAN: if (tmr_last) begin
                if (row_q != rows_last) begin
                    tmr_load = 1'b1; tmr_val = ac_eff;
                end else if (sus_total != '0) begin
                    state_d = SQ_SUSTAIN; sus_start = 1'b1;
                end else begin
                    sf_end = 1'b1;
                end
            end
            SQ_SUSTAIN: if (sus_done) sf_end = 1'b1;
            default: state_d = SQ_IDLE;
        endcase
        if (sf_end) begin
            if (last_sf) begin
                state_d = SQ_IDLE;
            end else begin
                state_d = SQ_BWRITE; tmr_load = 1'b1; tmr_val = w_eff;
            end
        end
    end

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            sf_q      <= '0;
            row_q     <= '0;
            pend_q    <= '0;
            cur_q     <= '0;
            first_q   <= 1'b0;
            req_d1_q  <= 1'b0;
            overrun_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            first_q   <= tmr_load | sus_start;
            req_d1_q  <= plane_req;
            overrun_q <= field_start && (state_q != SQ_IDLE);
            if (req_d1_q) pend_q <= plane_data;
            if (state_d == SQ_SCAN && tmr_load) cur_q <= req_d1_q ? plane_data : pend_q;
            if (state_q == SQ_IDLE && field_start) sf_q <= '0;
            else if (sf_end && !last_sf)           sf_q <= sf_q + SF_W'(1);
            if (state_q == SQ_BERASE && tmr_last) row_q <= '0;
            else if (state_q == SQ_SCAN && tmr_last && row_q != rows_last) row_q <= row_q + ROW_W'(1);
        end
    end

    // outputs
    always_comb begin
        bulk_write = (state_q == SQ_BWRITE);
        bulk_erase = (state_q == SQ_BERASE);
        sus_bias   = (state_q == SQ_PREFETCH) || (state_q == SQ_SCAN);
        scan_en    = (state_q == SQ_SCAN);
        scan_row   = scan_en ? row_q : '0;
        col_en     = scan_en ? cur_q : '0;
        plane_req  = first_q && ((state_q == SQ_PREFETCH) ||
                                 (state_q == SQ_SCAN && row_q != rows_last));
        plane_row  = (state_q == SQ_PREFETCH) ? row_q : row_q + ROW_W'(1);
        plane_sf   = sf_q;
        overrun    = overrun_q;
    end

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && $past(scan_en) && scan_row != $past(scan_row))
            |-> (scan_row == ROW_W'($past(scan_row) + 1'b1))); // R4
    AST_SF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_q != $past(sf_q)) |-> (sf_q == SF_W'($past(sf_q) + 1'b1) || sf_q == '0)); // R2
    AST_PREFETCH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en) |-> $past(sus_bias)); // R3
    AST_SUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (sus_x || sus_y) |-> !(sus_bias || bulk_write || bulk_erase)); // R6
endmodule

// File: tb/tb_pdp_subfield_seq.sv
module tb_pdp_subfield_seq;
    localparam int ROW_W = 8, NCOL = 8, CNT_W = 12, SF_W = 3;

    logic clk = 1'b0, rst_n = 1'b0, field_start = 1'b0;
    logic [ROW_W-1:0] cfg_rows = '0;
    logic [CNT_W-1:0] cfg_write_len = '0, cfg_erase_len = '0, cfg_addr_cyc = '0;
    logic [CNT_W-1:0] cfg_sus_width = '0, cfg_sus_base = '0;
    logic [NCOL-1:0]  plane_data = '0;
    logic             plane_req, bulk_write, bulk_erase, scan_en, sus_bias, sus_x, sus_y, overrun;
    logic [SF_W-1:0]  plane_sf;
    logic [ROW_W-1:0] plane_row, scan_row;
    logic [NCOL-1:0]  col_en;

    int checks = 0, failures = 0;
    logic [21:0] first_act, first_exp;

    always #10 clk = ~clk;

    pdp_subfield_seq dut (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .cfg_rows(cfg_rows),
        .cfg_write_len(cfg_write_len), .cfg_erase_len(cfg_erase_len),
        .cfg_addr_cyc(cfg_addr_cyc), .cfg_sus_width(cfg_sus_width),
        .cfg_sus_base(cfg_sus_base), .plane_data(plane_data), .plane_req(plane_req),
        .plane_sf(plane_sf), .plane_row(plane_row), .bulk_write(bulk_write),
        .bulk_erase(bulk_erase), .scan_en(scan_en), .scan_row(scan_row), .col_en(col_en),
        .sus_bias(sus_bias), .sus_x(sus_x), .sus_y(sus_y), .overrun(overrun)
    );

    function automatic logic [NCOL-1:0] plane_of(input int sf, input int row);
        logic [NCOL-1:0] v;
        for (int c = 0; c < NCOL; c++) begin
            logic [7:0] g;
            g = 8'((row * 37 + c * 11 + 5) & 255);
            v[c] = g[sf];
        end
        return v;
    endfunction

    // bit-plane store: one-cycle read latency
    always @(posedge clk) plane_data <= plane_req ? plane_of(int'(plane_sf), int'(plane_row)) : '0;

    task automatic check(input string req, input int bad);
        checks++;
        if (bad != 0) begin
            failures++;
            $display("FAIL %s: %0d bad cycles, first actual=%h expected=%h", req, bad, first_act, first_exp);
        end
    endtask

    task automatic cyc(input logic bw, be, sc, input int row, input logic [NCOL-1:0] col,
                       input logic bias, x, y, inout int bad);
        logic [21:0] a, e;
        a = {bulk_write, bulk_erase, scan_en, scan_row, col_en, sus_bias, sus_x, sus_y};
        e = {bw, be, sc, 8'(row), col, bias, x, y};
        if (a !== e) begin
            if (bad == 0) begin first_act = a; first_exp = e; end
            bad++;
        end
        @(negedge clk);
    endtask

    task automatic configure(input int rows, w, e, ac, sw, base);
        cfg_rows = 8'(rows); cfg_write_len = 12'(w); cfg_erase_len = 12'(e);
        cfg_addr_cyc = 12'(ac); cfg_sus_width = 12'(sw); cfg_sus_base = 12'(base);
    endtask

    task automatic pulse_start();
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
    endtask

    // walks one whole field from its first cycle; clamps follow R10
    task automatic walk_field(input int rows, w, e, ac, sw, base);
        int bad;
        int we = (w == 0) ? 1 : w, ee = (e == 0) ? 1 : e, ace = (ac < 2) ? 2 : ac;
        int swe = (sw == 0) ? 1 : sw, re = (rows == 0) ? 1 : rows;
        for (int sf = 0; sf < 8; sf++) begin
            bad = 0;
            for (int i = 0; i < we; i++) cyc(1, 0, 0, 0, '0, 0, 0, 0, bad);
            check((base == 0 && sf > 0) ? "R2 R7 R10 bulk write" : "R2 R10 bulk write", bad);
            bad = 0;
            for (int i = 0; i < ee; i++) cyc(0, 1, 0, 0, '0, 0, 0, 0, bad);
            check("R2 R10 bulk erase", bad);
            bad = 0;
            for (int i = 0; i < ace; i++) cyc(0, 0, 0, 0, '0, 1, 0, 0, bad);
            check("R3 prefetch slot", bad);
            for (int r = 0; r < re; r++) begin
                bad = 0;
                for (int i = 0; i < ace; i++) cyc(0, 0, 1, r, plane_of(sf, r), 1, 0, 0, bad);
                check("R4 R5 row scan", bad);
            end
            bad = 0;
            for (int p = 0; p < (base << sf); p++)
                for (int i = 0; i < swe; i++) cyc(0, 0, 0, 0, '0, 0, (p % 2) == 0, (p % 2) == 1, bad);
            if (base != 0) check("R6 sustain burst", bad);
        end
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            if (plane_req !== 1'b0) bad++;
            cyc(0, 0, 0, 0, '0, 0, 0, 0, bad);
        end
        check("R9 idle after last subfield", bad);
    endtask

    task automatic test_reset();
        int bad = 0;
        for (int i = 0; i < 4; i++) begin
            if ({plane_req, overrun} !== 2'b00) bad++;
            cyc(0, 0, 0, 0, '0, 0, 0, 0, bad);
        end
        check("R1 reset state", bad);
    endtask

    task automatic test_field(input int rows, w, e, ac, sw, base);
        configure(rows, w, e, ac, sw, base);
        pulse_start();
        walk_field(rows, w, e, ac, sw, base);
    endtask

    task automatic test_overrun();
        configure(2, 1, 1, 2, 1, 1);
        pulse_start();
        fork
            walk_field(2, 1, 1, 2, 1, 1);
            begin
                int bad = 0;
                repeat (30) @(negedge clk);
                if (overrun !== 1'b0) bad++;
                field_start = 1'b1;
                @(negedge clk);
                field_start = 1'b0;
                if (overrun !== 1'b1) bad++;
                @(negedge clk);
                if (overrun !== 1'b0) bad++;
                if (bad != 0) begin first_act = 22'(overrun); first_exp = 22'(0); end
                check("R8 overrun pulse", bad);
            end
        join
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_field(4, 3, 2, 3, 2, 1);   // R2 R4 R5 R6 main pattern
        test_field(1, 1, 1, 2, 1, 2);   // single row panel
        test_field(3, 2, 1, 4, 1, 0);   // R7 no display period
        test_field(2, 0, 0, 1, 0, 1);   // R10 clamps
        test_overrun();                 // R8
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule